// File: doc/BRIEF.md
# Low-Power Mode and Clock Gating Controller

This controller sits between software and the clock tree of a processor subsystem and decides, cycle by cycle, which clock domains receive their enable. In the run state the CPU clock, the oscillator and the PLL are enabled, and each peripheral clock follows its own bit in a software-written enable register. Software selects one of three sleep depths with a two-bit mode field and a one-cycle enter strobe. The block then drops the matching enables and waits for a wake source that suits that depth.

The shallow depth (IDLE) stops only the CPU clock. It leaves every peripheral whose enable bit is set running, and it wakes on an enabled interrupt from such a peripheral or on the watchdog. The middle depth (STANDBY) stops CPU and peripheral clocks but keeps the oscillator and PLL alive, and it returns to run one cycle after an external interrupt event. The deepest depth (HALT) also turns off the oscillator and PLL. Only a dedicated wake pin or reset ends it. After the wake pin is seen, the controller re-enables the oscillator and holds all consumer clocks off for a programmable settling time before run resumes.

The clock sources themselves are outside the block and are driven only through the enable outputs.

Top module: `lpm_clkctl`

## Requirements
- R1: After reset the state output reads RUN (code 0), the CPU, oscillator and PLL enables are 1, and every peripheral clock enable is 0.
- R2: In RUN, a one-cycle enter strobe moves the state in the next cycle according to the mode field: 2'b00 gives IDLE (code 1), 2'b01 gives STANDBY (code 2), and 2'b10 or 2'b11 give HALT (code 3). WAKE_WAIT has code 4.
- R3: In IDLE the CPU enable is 0, the oscillator and PLL enables are 1, and each peripheral clock enable equals its register bit.
- R4: In IDLE, the state returns to RUN in the next cycle when the watchdog input is high or when any peripheral has its interrupt, its interrupt mask bit and its clock enable bit all set. An interrupt from a peripheral whose clock bit or mask bit is clear has no effect.
- R5: In STANDBY the CPU enable and all peripheral clock enables are 0, while the oscillator and PLL enables stay 1.
- R6: In STANDBY, the external event input returns the state to RUN in the next cycle. Peripheral interrupts and the watchdog have no effect.
- R7: In HALT all enables, including the oscillator and PLL enables, are 0. The peripheral interrupts, the watchdog and the external event input have no effect. Only the halt wake pin (or reset) leaves HALT.
- R8: The halt wake pin moves HALT to WAKE_WAIT. The settle value is sampled in that same cycle. WAKE_WAIT lasts exactly settle+1 cycles with the oscillator and PLL enables at 1 and the CPU and peripheral enables at 0, and then the state is RUN.
- R9: A write strobe loads the peripheral enable register from the data input in the next cycle. In RUN each peripheral clock enable equals its register bit.
- R10: An enter strobe while the state is not RUN is ignored.
- R11: When a register write and an enter strobe to IDLE fall in the same cycle, the IDLE peripheral enables show the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested sleep depth |
| enter_i | input | 1 | One-cycle request to enter the selected depth |
| pclk_wr_i | input | 1 | Write strobe for the peripheral enable register |
| pclk_wdata_i | input | NPERIPH | New peripheral enable register value |
| periph_irq_i | input | NPERIPH | Interrupt lines from the peripherals |
| irq_mask_i | input | NPERIPH | Per-peripheral interrupt enable bits |
| wdog_i | input | 1 | Watchdog wake event |
| ext_evt_i | input | 1 | External interrupt event |
| halt_wake_i | input | 1 | Wake pin for the deepest depth |
| settle_i | input | SETTLE_W | Oscillator settling length after HALT |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | NPERIPH | Per-peripheral clock enables |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| state_o | output | 3 | Current state code |

## Verification
A register write and an enter strobe can land in the same cycle. They touch the same state, because the IDLE gating uses the register that the write updates. The bench raises both strobes on one clock edge, with a value that differs from the old register contents. The write is judged to have won when the IDLE peripheral enables show the new value in the first sleeping cycle. The bench also holds wake sources that do not belong to the current depth while the controller sleeps, and it times the WAKE_WAIT span edge by edge for a nonzero and a zero settle value.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        LPM_RUN   = 3'd0,
        LPM_IDLE  = 3'd1,
        LPM_STBY  = 3'd2,
        LPM_HALT  = 3'd3,
        LPM_WWAIT = 3'd4
    } lpm_state_e;

    localparam logic [1:0] MODE_IDLE = 2'b00;
    localparam logic [1:0] MODE_STBY = 2'b01;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  lpm_state_e           state_i,
    input  logic [NPERIPH-1:0]   pclk_en_i,
    input  logic [NPERIPH-1:0]   irq_i,
    input  logic [NPERIPH-1:0]   irq_mask_i,
    input  logic                 wdog_i,
    input  logic                 ext_evt_i,
    input  logic                 halt_wake_i,
    output logic                 wake_o
);

    logic [NPERIPH-1:0] live_irq;

    // a peripheral can only raise a wake when it is clocked and unmasked
    genvar g;
    generate
        for (g = 0; g < NPERIPH; g++) begin : g_live
            assign live_irq[g] = irq_i[g] & irq_mask_i[g] & pclk_en_i[g];
        end
    endgenerate

    always_comb begin
        case (state_i)
            LPM_IDLE: wake_o = (|live_irq) | wdog_i;
            LPM_STBY: wake_o = ext_evt_i;
            LPM_HALT: wake_o = halt_wake_i;
            default:  wake_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                run_i,
    output logic                done_o
);

    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = settle_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - SETTLE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == '0);

    AST_SETTLE_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - SETTLE_W'(1))); // R8

    AST_SETTLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(settle_i))); // R8

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  lpm_state_e         state_i,
    input  logic [NPERIPH-1:0] pclk_reg_i,
    output logic               cpu_en_o,
    output logic [NPERIPH-1:0] periph_en_o,
    output logic               osc_en_o,
    output logic               pll_en_o
);

    logic periph_pass;

    always_comb begin
        cpu_en_o    = 1'b0;
        periph_pass = 1'b0;
        osc_en_o    = 1'b1;
        pll_en_o    = 1'b1;
        case (state_i)
            LPM_RUN: begin
                cpu_en_o    = 1'b1;
                periph_pass = 1'b1;
            end
            LPM_IDLE:  periph_pass = 1'b1;
            LPM_STBY:  periph_pass = 1'b0;
            LPM_HALT: begin
                osc_en_o = 1'b0;
                pll_en_o = 1'b0;
            end
            default: begin
                cpu_en_o    = 1'b0;
                periph_pass = 1'b0;
            end
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NPERIPH; g++) begin : g_pgate
            assign periph_en_o[g] = pclk_reg_i[g] & periph_pass;
        end
    endgenerate

endmodule

// File: rtl/lpm_clkctl.sv
module lpm_clkctl
    import lpm_pkg::*;
#(
    parameter int NPERIPH  = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                enter_i,
    input  logic                pclk_wr_i,
    input  logic [NPERIPH-1:0]  pclk_wdata_i,
    input  logic [NPERIPH-1:0]  periph_irq_i,
    input  logic [NPERIPH-1:0]  irq_mask_i,
    input  logic                wdog_i,
    input  logic                ext_evt_i,
    input  logic                halt_wake_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                cpu_clk_en_o,
    output logic [NPERIPH-1:0]  periph_clk_en_o,
    output logic                osc_en_o,
    output logic                pll_en_o,
    output logic [2:0]          state_o
);

    typedef struct packed {
        lpm_state_e         st;
        logic [NPERIPH-1:0] pclk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wake;
    logic settle_load;
    logic settle_done;

    lpm_wake_qual #(.NPERIPH(NPERIPH)) wake_i (
        .state_i     (ctl_q.st),
        .pclk_en_i   (ctl_q.pclk),
        .irq_i       (periph_irq_i),
        .irq_mask_i  (irq_mask_i),
        .wdog_i      (wdog_i),
        .ext_evt_i   (ext_evt_i),
        .halt_wake_i (halt_wake_i),
        .wake_o      (wake)
    );

    lpm_settle_cnt #(.SETTLE_W(SETTLE_W)) settle_i_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (settle_load),
        .settle_i (settle_i),
        .run_i    (ctl_q.st == LPM_WWAIT),
        .done_o   (settle_done)
    );

    always_comb begin
        ctl_d       = ctl_q;
        settle_load = 1'b0;
        if (pclk_wr_i) ctl_d.pclk = pclk_wdata_i;
        case (ctl_q.st)
            LPM_RUN: begin
                if (enter_i) begin
                    case (mode_i)
                        MODE_IDLE: ctl_d.st = LPM_IDLE;
                        MODE_STBY: ctl_d.st = LPM_STBY;
                        default:   ctl_d.st = LPM_HALT;
                    endcase
                end
            end
            LPM_IDLE, LPM_STBY: begin
                if (wake) ctl_d.st = LPM_RUN;
            end
            LPM_HALT: begin
                if (wake) begin
                    ctl_d.st    = LPM_WWAIT;
                    settle_load = 1'b1;
                end
            end
            LPM_WWAIT: begin
                if (settle_done) ctl_d.st = LPM_RUN;
            end
            default: ctl_d.st = LPM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= LPM_RUN;
            ctl_q.pclk <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lpm_gate_dec #(.NPERIPH(NPERIPH)) gate_i (
        .state_i     (ctl_q.st),
        .pclk_reg_i  (ctl_q.pclk),
        .cpu_en_o    (cpu_clk_en_o),
        .periph_en_o (periph_clk_en_o),
        .osc_en_o    (osc_en_o),
        .pll_en_o    (pll_en_o)
    );

    assign state_o = ctl_q.st;

    AST_ENTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_RUN && enter_i && mode_i == 2'b00) |=> (state_o == 3'd1)); // R2

    AST_IDLE_PERIPH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_IDLE) |-> (periph_clk_en_o == ctl_q.pclk && !cpu_clk_en_o)); // R3

    AST_STBY_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_STBY && ext_evt_i) |=> (state_o == 3'd0)); // R6

    AST_HALT_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_HALT) |-> (!osc_en_o && !pll_en_o && !cpu_clk_en_o)); // R7

    AST_HALT_EXIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_HALT) |=> (ctl_q.st == LPM_HALT || ctl_q.st == LPM_WWAIT)); // R7

    AST_WWAIT_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_WWAIT) |-> (osc_en_o && pll_en_o && periph_clk_en_o == '0)); // R8

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_wr_i |=> (ctl_q.pclk == $past(pclk_wdata_i))); // R9

    AST_ENTER_IGNORED_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LPM_IDLE && enter_i && !wake) |=> (ctl_q.st == LPM_IDLE)); // R10

endmodule

// File: tb/lpm_clkctl_tb_top.sv
`timescale 1ns/1ps
module lpm_clkctl_tb_top;

    localparam int NP = 8;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          enter_i = 1'b0;
    logic          pclk_wr_i = 1'b0;
    logic [NP-1:0] pclk_wdata_i = '0;
    logic [NP-1:0] periph_irq_i = '0;
    logic [NP-1:0] irq_mask_i = '0;
    logic          wdog_i = 1'b0;
    logic          ext_evt_i = 1'b0;
    logic          halt_wake_i = 1'b0;
    logic [SW-1:0] settle_i = '0;
    logic          cpu_clk_en_o;
    logic [NP-1:0] periph_clk_en_o;
    logic          osc_en_o;
    logic          pll_en_o;
    logic [2:0]    state_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpm_clkctl #(.NPERIPH(NP), .SETTLE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enter_i(enter_i),
        .pclk_wr_i(pclk_wr_i), .pclk_wdata_i(pclk_wdata_i),
        .periph_irq_i(periph_irq_i), .irq_mask_i(irq_mask_i),
        .wdog_i(wdog_i), .ext_evt_i(ext_evt_i), .halt_wake_i(halt_wake_i),
        .settle_i(settle_i), .cpu_clk_en_o(cpu_clk_en_o),
        .periph_clk_en_o(periph_clk_en_o), .osc_en_o(osc_en_o),
        .pll_en_o(pll_en_o), .state_o(state_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one strobe cycle; the result is sampled at the following negedge
    task automatic enter_mode(input logic [1:0] m);
        @(negedge clk);
        mode_i  = m;
        enter_i = 1'b1;
        @(negedge clk);
        enter_i = 1'b0;
    endtask

    task automatic write_pclk(input logic [NP-1:0] v);
        @(negedge clk);
        pclk_wr_i    = 1'b1;
        pclk_wdata_i = v;
        @(negedge clk);
        pclk_wr_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "state", 32'(state_o), 32'd0);
        chk("R1", "cpu", 32'(cpu_clk_en_o), 32'd1);
        chk("R1", "osc/pll", 32'({osc_en_o, pll_en_o}), 32'd3);
        chk("R1", "periph", 32'(periph_clk_en_o), 32'd0);
    endtask

    task automatic t_reg_write;
        write_pclk(8'hA5);
        chk("R9", "periph in run", 32'(periph_clk_en_o), 32'hA5);
        chk("R9", "cpu in run", 32'(cpu_clk_en_o), 32'd1);
    endtask

    task automatic t_idle;
        irq_mask_i = 8'hFE;
        enter_mode(2'b00);
        chk("R2", "idle code", 32'(state_o), 32'd1);
        chk("R3", "cpu", 32'(cpu_clk_en_o), 32'd0);
        chk("R3", "periph", 32'(periph_clk_en_o), 32'hA5);
        chk("R3", "osc/pll", 32'({osc_en_o, pll_en_o}), 32'd3);
        // bit1 has clock clear, bit0 has mask clear: no wake
        @(negedge clk);
        periph_irq_i = 8'h03;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "unqualified irq", 32'(state_o), 32'd1);
        enter_mode(2'b01);
        chk("R10", "enter asleep", 32'(state_o), 32'd1);
        periph_irq_i = 8'h00;
        irq_mask_i   = 8'hFF;
        @(negedge clk);
        periph_irq_i = 8'h01;
        @(negedge clk);
        periph_irq_i = 8'h00;
        chk("R4", "irq wake", 32'(state_o), 32'd0);
        enter_mode(2'b00);
        chk("R2", "idle again", 32'(state_o), 32'd1);
        wdog_i = 1'b1;
        @(negedge clk);
        wdog_i = 1'b0;
        chk("R4", "wdog wake", 32'(state_o), 32'd0);
    endtask

    task automatic t_standby;
        enter_mode(2'b01);
        chk("R2", "standby code", 32'(state_o), 32'd2);
        chk("R5", "cpu/periph", 32'({cpu_clk_en_o, periph_clk_en_o}), 32'd0);
        chk("R5", "osc/pll", 32'({osc_en_o, pll_en_o}), 32'd3);
        periph_irq_i = 8'hFF;
        wdog_i       = 1'b1;
        @(negedge clk);
        @(negedge clk);
        periph_irq_i = 8'h00;
        wdog_i       = 1'b0;
        chk("R6", "irq/wdog ignored", 32'(state_o), 32'd2);
        enter_mode(2'b10);
        chk("R10", "enter in standby", 32'(state_o), 32'd2);
        ext_evt_i = 1'b1;
        @(negedge clk);
        ext_evt_i = 1'b0;
        chk("R6", "ext wake", 32'(state_o), 32'd0);
        chk("R6", "cpu back", 32'(cpu_clk_en_o), 32'd1);
    endtask

    task automatic t_halt(input logic [1:0] m, input int settle);
        int n;
        enter_mode(m);
        chk("R2", "halt code", 32'(state_o), 32'd3);
        chk("R7", "all off", 32'({cpu_clk_en_o, osc_en_o, pll_en_o, periph_clk_en_o}), 32'd0);
        periph_irq_i = 8'hFF;
        wdog_i       = 1'b1;
        ext_evt_i    = 1'b1;
        @(negedge clk);
        @(negedge clk);
        periph_irq_i = 8'h00;
        wdog_i       = 1'b0;
        ext_evt_i    = 1'b0;
        chk("R7", "other wakes ignored", 32'(state_o), 32'd3);
        settle_i    = SW'(settle);
        halt_wake_i = 1'b1;
        @(negedge clk);
        halt_wake_i = 1'b0;
        settle_i    = 8'hFF;
        chk("R8", "wake_wait code", 32'(state_o), 32'd4);
        chk("R8", "osc/pll on", 32'({osc_en_o, pll_en_o}), 32'd3);
        chk("R8", "cpu/periph off", 32'({cpu_clk_en_o, periph_clk_en_o}), 32'd0);
        n = 0;
        while (state_o == 3'd4 && n < 400) begin
            n++;
            @(negedge clk);
        end
        chk("R8", "wait length", 32'(n), 32'(settle + 1));
        chk("R8", "back to run", 32'(state_o), 32'd0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        pclk_wr_i    = 1'b1;
        pclk_wdata_i = 8'h3C;
        mode_i       = 2'b00;
        enter_i      = 1'b1;
        @(negedge clk);
        pclk_wr_i = 1'b0;
        enter_i   = 1'b0;
        chk("R11", "state", 32'(state_o), 32'd1);
        chk("R11", "new periph value", 32'(periph_clk_en_o), 32'h3C);
        wdog_i = 1'b1;
        @(negedge clk);
        wdog_i = 1'b0;
        chk("R9", "run periph", 32'(periph_clk_en_o), 32'h3C);
    endtask

    initial begin
        #1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_write();
        t_idle();
        t_standby();
        t_halt(2'b10, 5);
        t_halt(2'b11, 0);
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule